// File: doc/BRIEF.md
# RMII Receive Byte Aligner

This block sits behind an RMII receive port and turns the two-bit receive stream into bytes. All of its logic runs on the 50 MHz reference clock shared with the PHY. In every cycle where the carrier/data-valid input is high, the block samples one dibit. While it is searching, it keeps a history window of the most recent valid dibits and compares that window against the full preamble-and-delimiter pattern. The pattern is thirty-one `01` dibits followed by one `11` dibit.

A match fixes the byte boundary. From the dibit after the delimiter onward, the block collects groups of four dibits into bytes, least-significant dibit first. It presents each completed byte with a one-cycle strobe. It marks the start of a frame with a one-cycle pulse on alignment. When the valid input drops, it marks the end of the frame with a one-cycle pulse, throws away any incomplete byte and returns to searching. Header fields and the frame check sequence are left to downstream logic.

Top module: `rmii_rx_deser`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and on the first cycle after it is released, all three pulse outputs are low and the byte output is zero. The block is not aligned after reset, so valid data that arrives afterwards produces no byte strobe and no end pulse until a new delimiter is found.
- R2: Consider a clock edge that samples a `11` dibit with valid high, where the 31 dibits sampled on the preceding valid edges were all `01` with no gap in valid. The start pulse is high for exactly the cycle that follows that edge.
- R3: No alignment takes place, and so no start pulse, byte strobe or end pulse is produced, in any of these cases: fewer than 31 consecutive `01` dibits before the `11`; any other dibit value inside the last 31; valid dropping inside the run.
- R4: Each byte places the first dibit after the delimiter in bits [1:0], the second in [3:2], the third in [5:4] and the fourth in [7:6].
- R5: The byte strobe is a one-cycle pulse. It is high in the cycle after the edge that samples each fourth dibit counted from the delimiter. At most one of the start pulse, end pulse and byte strobe is high in any cycle.
- R6: While not aligned, the byte strobe stays low whatever the input carries.
- R7: When valid is sampled low while the block is aligned, the end pulse is high for exactly the next cycle. Any one to three leftover dibits produce no byte. The dibit value on a cycle with valid low has no effect.
- R8: While aligned, payload that reproduces the delimiter pattern produces no second start pulse. After an end pulse, a complete 31-dibit preamble is required again.
- R9: The byte output holds the most recently completed byte until the next strobe.
- R10: Valid dropping while the block is not aligned produces no end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv_i | input | 1 | Carrier/data-valid qualifier |
| rx_dibit_i | input | 2 | Receive dibit |
| byte_data_o | output | 8 | Last completed byte |
| byte_valid_o | output | 1 | One-cycle strobe for a new byte |
| sof_o | output | 1 | One-cycle pulse on delimiter match |
| eof_o | output | 1 | One-cycle pulse when valid ends an aligned frame |

## Verification
The hardest case to reach is the exact edge of the match window. The bench has to show that a run of thirty `01` dibits is rejected, that thirty-one is accepted, and that a single bad dibit at any position inside the last thirty-one prevents alignment, while a bad dibit just outside that window does not. To cover this, the bench sweeps the preamble length across the threshold and moves a corrupted dibit through every position of a minimal preamble. A further frame carries a delimiter-shaped run inside its payload, and a reset is applied in the middle of a payload, so that both the protection against realignment and the return to searching are seen at the ports.

// File: rtl/rmii_rx_pkg.sv
`timescale 1ns/1ps
package rmii_rx_pkg;
  typedef logic [1:0] dibit_t;
  localparam dibit_t DIBIT_PRE = 2'b01;
  localparam dibit_t DIBIT_SFD = 2'b11;
endpackage

// File: rtl/rmii_sfd_detect.sv
`timescale 1ns/1ps
module rmii_sfd_detect
  import rmii_rx_pkg::*;
#(
  parameter int PRE_DIBITS = 31
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   dv_i,
  input  dibit_t dibit_i,
  input  logic   armed_i,
  output logic   match_o
);
  localparam int WIN_DIBITS = PRE_DIBITS + 1;
  localparam int WIN_W      = 2 * WIN_DIBITS;
  localparam int HIST_W     = WIN_W - 2;

  logic [HIST_W-1:0] hist_q, hist_d;
  logic              hist_en;
  logic [WIN_W-1:0]  window;
  logic [WIN_W-1:0]  pattern;

  // Expected window: delimiter dibit newest (low bits), preamble dibits older.
  always_comb begin
    pattern = '0;
    pattern[1:0] = DIBIT_SFD;
    for (int i = 1; i < WIN_DIBITS; i++) begin
      pattern[2*i +: 2] = DIBIT_PRE;
    end
  end

  // Window formed from history plus the dibit being sampled this edge.
  assign window = {hist_q, dibit_i};

  // History shifts while searching, is cleared when valid drops, holds while aligned.
  assign hist_en = armed_i | ~dv_i;

  always_comb begin
    if (dv_i) hist_d = window[HIST_W-1:0];
    else      hist_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  assign match_o = armed_i & dv_i & (window == pattern);

  // A full window implies the previous edge also carried valid data.
  assert_match_prev_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(dv_i));
endmodule

// File: rtl/rmii_byte_pack.sv
`timescale 1ns/1ps
module rmii_byte_pack
  import rmii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dv_i,
  input  dibit_t            dibit_i,
  input  logic              start_i,
  output logic              aligned_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              eof_o
);
  localparam int DPB   = BYTE_W / 2;
  localparam int CNT_W = (DPB > 1) ? $clog2(DPB) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DPB - 1);

  logic              aligned_q, aligned_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] asm_q, asm_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d, sof_q, sof_d, eof_q, eof_d;
  logic              asm_en, byte_en;

  always_comb begin
    aligned_d = aligned_q;
    cnt_d     = cnt_q;
    asm_d     = {dibit_i, asm_q[BYTE_W-1:2]};
    byte_d    = asm_d;
    asm_en    = 1'b0;
    vld_d     = 1'b0;
    sof_d     = 1'b0;
    eof_d     = 1'b0;
    if (aligned_q) begin
      if (dv_i) begin
        asm_en = 1'b1;
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          vld_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        aligned_d = 1'b0;
        cnt_d     = '0;
        eof_d     = 1'b1;
      end
    end else if (start_i) begin
      aligned_d = 1'b1;
      cnt_d     = '0;
      sof_d     = 1'b1;
    end
  end

  assign byte_en = vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      cnt_q     <= '0;
      vld_q     <= 1'b0;
      sof_q     <= 1'b0;
      eof_q     <= 1'b0;
    end else begin
      aligned_q <= aligned_d;
      cnt_q     <= cnt_d;
      vld_q     <= vld_d;
      sof_q     <= sof_d;
      eof_q     <= eof_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      asm_q <= '0;
    else if (asm_en) asm_q <= asm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= byte_d;
  end

  assign aligned_o  = aligned_q;
  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign sof_o      = sof_q;
  assign eof_o      = eof_q;

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  assert_no_strobe_unaligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(aligned_q));
  assert_eof_after_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q |-> !$past(dv_i));
  assert_eof_only_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q |-> $past(aligned_q));
endmodule

// File: rtl/rmii_rx_deser.sv
`timescale 1ns/1ps
module rmii_rx_deser
  import rmii_rx_pkg::*;
#(
  parameter int PRE_DIBITS = 31,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dv_i,
  input  logic [1:0]        rx_dibit_i,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              byte_valid_o,
  output logic              sof_o,
  output logic              eof_o
);
  logic aligned;
  logic match;

  rmii_sfd_detect #(.PRE_DIBITS(PRE_DIBITS)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .dv_i    (rx_dv_i),
    .dibit_i (rx_dibit_i),
    .armed_i (~aligned),
    .match_o (match)
  );

  rmii_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .dv_i       (rx_dv_i),
    .dibit_i    (rx_dibit_i),
    .start_i    (match),
    .aligned_o  (aligned),
    .byte_o     (byte_data_o),
    .byte_vld_o (byte_valid_o),
    .sof_o      (sof_o),
    .eof_o      (eof_o)
  );

  assert_events_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_o, eof_o, byte_valid_o}));
  assert_sof_after_sfd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> $past(rx_dv_i && rx_dibit_i == DIBIT_SFD));
  assert_byte_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid_o |-> $stable(byte_data_o));
  assert_no_resync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |=> !sof_o);
endmodule

// File: tb/rmii_rx_deser_tb.sv
`timescale 1ns/1ps
module rmii_rx_deser_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_dv = 1'b0;
  logic [1:0] rx_dibit = 2'b00;
  logic [7:0] byte_data;
  logic       byte_valid, sof, eof;

  int pass_cnt = 0;
  int fail_cnt = 0;
  int cyc = 0;
  int last_edge = 0;

  logic [7:0] payload  [0:511];
  logic [7:0] obs_byte [0:511];
  int         obs_cyc  [0:511];
  logic [7:0] exp_byte [0:511];
  int         exp_cyc  [0:511];
  int n_obs = 0, n_exp = 0, sof_cnt = 0, eof_cnt = 0, sof_cyc = 0, eof_cyc = 0;

  always #4 clk = ~clk;

  rmii_rx_deser dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_dv_i      (rx_dv),
    .rx_dibit_i   (rx_dibit),
    .byte_data_o  (byte_data),
    .byte_valid_o (byte_valid),
    .sof_o        (sof),
    .eof_o        (eof)
  );

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid && n_obs < 512) begin
        obs_byte[n_obs] = byte_data;
        obs_cyc[n_obs]  = cyc;
        n_obs = n_obs + 1;
      end
      if (sof) begin sof_cnt = sof_cnt + 1; sof_cyc = cyc; end
      if (eof) begin eof_cnt = eof_cnt + 1; eof_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic dv, input logic [1:0] d);
    @(negedge clk);
    rx_dv = dv;
    rx_dibit = d;
    last_edge = cyc + 1;
  endtask

  task automatic clear_obs();
    n_obs = 0; n_exp = 0; sof_cnt = 0; eof_cnt = 0;
  endtask

  task automatic run_frame(input int pre_len, input int corrupt_at, input int nbytes, input int tail);
    bit aligned_exp;
    int sfd_edge, drop_edge;
    clear_obs();
    aligned_exp = (pre_len >= 31) && (corrupt_at < 0 || corrupt_at < pre_len - 31);
    for (int i = 0; i < pre_len; i++)
      drive(1'b1, (i == corrupt_at) ? ((i % 2 == 1) ? 2'b11 : 2'b00) : 2'b01);
    drive(1'b1, 2'b11);
    sfd_edge = last_edge;
    for (int b = 0; b < nbytes; b++) begin
      for (int k = 0; k < 4; k++) begin
        drive(1'b1, payload[b][2*k +: 2]);
        if (aligned_exp && k == 3) begin
          exp_byte[n_exp] = payload[b];
          exp_cyc[n_exp]  = last_edge;
          n_exp++;
        end
      end
    end
    for (int t = 0; t < tail; t++) drive(1'b1, 2'b10);
    drive(1'b0, 2'b11);
    drop_edge = last_edge;
    for (int j = 0; j < 3; j++) drive(1'b0, 2'b01);
    chk(sof_cnt == (aligned_exp ? 1 : 0), aligned_exp ? "R2 sof count" : "R3 sof count",
        sof_cnt, aligned_exp ? 1 : 0);
    if (aligned_exp) chk(sof_cyc == sfd_edge, "R2 sof cycle", sof_cyc, sfd_edge);
    chk(n_obs == n_exp, aligned_exp ? "R5 byte count" : "R6 byte count", n_obs, n_exp);
    for (int i = 0; i < n_obs && i < n_exp; i++) begin
      chk(obs_byte[i] == exp_byte[i], "R4 byte value", obs_byte[i], exp_byte[i]);
      chk(obs_cyc[i] == exp_cyc[i], "R5 strobe cycle", obs_cyc[i], exp_cyc[i]);
    end
    if (tail > 0 && aligned_exp) chk(n_obs == nbytes, "R7 partial dropped", n_obs, nbytes);
    chk(eof_cnt == (aligned_exp ? 1 : 0), aligned_exp ? "R7 eof count" : "R10 eof count",
        eof_cnt, aligned_exp ? 1 : 0);
    if (aligned_exp) chk(eof_cyc == drop_edge, "R7 eof cycle", eof_cyc, drop_edge);
    if (aligned_exp && n_exp > 0)
      chk(byte_data == exp_byte[n_exp-1], "R9 byte hold", byte_data, exp_byte[n_exp-1]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  %0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!sof && !eof && !byte_valid, "R1 pulses in reset", {sof, eof, byte_valid}, 0);
    chk(byte_data == 8'h00, "R1 byte in reset", byte_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sof && !eof && !byte_valid && byte_data == 0, "R1 after release",
        {sof, eof, byte_valid, byte_data}, 0);
    drive(1'b0, 2'b00);

    for (int b = 0; b < 512; b++) payload[b] = 8'((b * 37 + 11) & 8'hFF);

    // R2/R3: preamble length sweep across the threshold
    for (int p = 28; p <= 34; p++) run_frame(p, -1, 3, 0);

    // R3: a corrupted dibit at every window position
    for (int c = 0; c < 31; c++) run_frame(31, c, 2, 0);
    run_frame(40, 8, 2, 0);
    run_frame(40, 9, 2, 0);

    // R4: every byte value in one frame
    for (int b = 0; b < 256; b++) payload[b] = 8'(b);
    run_frame(31, -1, 256, 0);

    // R7: partial trailing byte
    for (int b = 0; b < 512; b++) payload[b] = 8'((b * 37 + 11) & 8'hFF);
    for (int t = 1; t <= 3; t++) run_frame(31, -1, 5, t);

    // R8: delimiter inside payload, then re-arm needs a full preamble
    for (int b = 0; b < 7; b++) payload[b] = 8'h55;
    payload[7] = 8'hD5;
    for (int b = 8; b < 12; b++) payload[b] = 8'(8'hA0 + b);
    run_frame(31, -1, 12, 0);
    chk(sof_cnt == 1, "R8 no second sof", sof_cnt, 1);
    run_frame(30, -1, 3, 0);
    chk(sof_cnt == 0, "R8 re-arm needs full preamble", sof_cnt, 0);

    // R3/R10: valid gap inside the preamble
    clear_obs();
    for (int i = 0; i < 15; i++) drive(1'b1, 2'b01);
    drive(1'b0, 2'b01);
    for (int i = 0; i < 16; i++) drive(1'b1, 2'b01);
    drive(1'b1, 2'b11);
    for (int i = 0; i < 8; i++) drive(1'b1, 2'(i));
    drive(1'b0, 2'b00);
    for (int j = 0; j < 3; j++) drive(1'b0, 2'b00);
    chk(sof_cnt == 0, "R3 gap no sof", sof_cnt, 0);
    chk(n_obs == 0, "R6 gap no bytes", n_obs, 0);
    chk(eof_cnt == 0, "R10 gap no eof", eof_cnt, 0);

    // R1: reset in the middle of a payload
    clear_obs();
    for (int i = 0; i < 31; i++) drive(1'b1, 2'b01);
    drive(1'b1, 2'b11);
    for (int i = 0; i < 10; i++) drive(1'b1, 2'b10);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!sof && !eof && !byte_valid && byte_data == 0, "R1 mid-frame reset",
        {sof, eof, byte_valid, byte_data}, 0);
    rst_n = 1'b1;
    clear_obs();
    for (int i = 0; i < 12; i++) drive(1'b1, 2'b01);
    drive(1'b0, 2'b00);
    for (int j = 0; j < 3; j++) drive(1'b0, 2'b00);
    chk(n_obs == 0, "R1 no bytes after reset", n_obs, 0);
    chk(eof_cnt == 0, "R1 no eof after reset", eof_cnt, 0);
    chk(byte_data == 0, "R1 byte cleared", byte_data, 0);

    // recovery frame after reset
    run_frame(33, -1, 4, 0);

    $display("  %0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule